// File: doc/BRIEF.md
# SPI Master Frame Shift Engine

This block moves one serial frame at a time between a small register port and the SPI data pins. Software writes bytes into an eight-entry transmit queue and reads received frames from an eight-entry receive queue. Whenever the transmit queue holds a byte, the engine raises a start request. An outside chip-select sequencer answers with a grant, and the engine then clocks one frame out on SCK while sampling the data lanes. When the frame ends, the engine reports it with a one-cycle done pulse.

The serial clock rate comes from a divisor. Polarity and phase are runtime settings, and so is the lane count: one, two or four lanes per SCK period. Bit order and frame length (one to eight bits) are also runtime settings. A direction bit controls two things. It decides whether the multi-lane data pins are driven, and whether received frames are kept.

Register port: word addresses on `reg_addr`. Reads are combinational in the same cycle. A read strobe on the receive data address pops one entry.

| Address | Contents |
|---|---|
| 0 | Divisor, bits 11:0 |
| 1 | Clock mode: bit 0 is phase, bit 1 is idle level |
| 2 | Format: bits 1:0 lane protocol, bit 2 LSB-first, bit 3 transmit-only, bits 19:16 frame length |
| 3 | Transmit data: write bits 7:0, read bit 31 as full |
| 4 | Receive data: bits 7:0 data, bit 31 empty |

Any other address reads as zero.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the divisor reads 1, the clock mode reads 0 and the format reads 0x00080000. SCK is low, all output enables are 0, frame_req is 0, the transmit data register reads 0 and the receive data register reads 0x80000000.
- R2: During a frame, each SCK period lasts 2×(divisor+1) clock cycles. SCK holds its idle level for the first divisor+1 cycles of each period and the opposite level for the rest.
- R3: Clock mode bit 1 sets the SCK idle level. With bit 0 clear, each lane group is presented before the leading edge, sampled on the leading edge and changed on the trailing edge. With bit 0 set, the group changes on the leading edge and is sampled on the trailing edge.
- R4: Protocol field value 1 uses lanes 1:0 as a pair. Value 2 uses lanes 3:0 as a nibble. Values 0 and 3 use single mode: DQ0 is the output and DQ1 is the input.
- R5: With format bit 2 clear the frame goes most significant bit first, and the lowest-numbered lane of a group carries the last bit. With format bit 2 set the frame goes least significant bit first, and lane 0 carries the earliest bit.
- R6: The frame length field L sits at format bits 19:16. Values 0 and above 8 act as 8. The frame uses the low L bits of the byte and lasts ceil(L/lanes) SCK periods. Unused trailing lane slots carry 0. The received value is the first L sampled bits, zero-extended.
- R7: In single mode DQ0 is driven for the whole frame. In dual or quad mode the used lanes are driven only when format bit 3 is set. With bit 3 set no received frame is queued. All enables are 0 outside frames.
- R8: A write to address 3 queues bits 7:0. Reading address 3 returns the full flag in bit 31. A write while the queue is full is dropped.
- R9: A read of address 4 returns the oldest received frame in bits 7:0 and pops it. When the queue is empty the read returns bit 31 set and data 0. A frame that completes while the receive queue holds 8 entries is discarded.
- R10: frame_req is high exactly when no frame is active and the transmit queue is non-empty. A frame starts on a clock where frame_req and frame_go are both high. frame_done pulses for one cycle right after the final SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 4) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| frame_req | output | 1 | Frame ready to start |
| frame_go | input | 1 | Start grant from chip-select sequencer |
| frame_done | output | 1 | One-cycle pulse after a frame ends |
| sck | output | 1 | Serial clock |
| dq_o | output | 4 | Data lane outputs |
| dq_oe | output | 4 | Data lane output enables |
| dq_i | input | 4 | Data lane inputs |

## Verification
The bench uses the default parameters: queue depth 8 and a 12-bit divisor. The shallow queues reach both the dropped transmit write and the discarded receive frame within a few dozen frames. Divisor values from 0 to 2 keep every frame short, so all four clock modes can be compared cycle by cycle. The run also covers all protocol codes, both bit orders, and odd frame lengths that leave padded lane slots.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DEPTH = 8,
  parameter int DIVW  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        frame_req,
  input  logic        frame_go,
  output logic        frame_done,
  output logic        sck,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_N = (AW+1)'(DEPTH);

  logic [DIVW-1:0] div_q, cnt;
  logic [1:0] mode_q, proto_q;
  logic lsb_q, txo_q;
  logic [3:0] len_q, step;
  logic busy, half;
  logic [7:0] sh, rx, outq;
  logic [7:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [AW:0] tx_cnt, rx_cnt;
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:20], reg_wdata[15:12]};

  function automatic logic [3:0] lane_out(logic [7:0] s, logic [1:0] p, logic l);
    case (p)
      2'd1: lane_out = l ? {2'b0, s[1:0]} : {2'b0, s[7:6]};
      2'd2: lane_out = l ? s[3:0] : s[7:4];
      default: lane_out = l ? {3'b0, s[0]} : {3'b0, s[7]};
    endcase
  endfunction

  function automatic logic [7:0] lane_shift(logic [7:0] s, logic [1:0] p, logic l);
    case (p)
      2'd1: lane_shift = l ? {2'b0, s[7:2]} : {s[5:0], 2'b0};
      2'd2: lane_shift = l ? {4'b0, s[7:4]} : {s[3:0], 4'b0};
      default: lane_shift = l ? {1'b0, s[7:1]} : {s[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] lane_in(logic [7:0] r, logic [3:0] d, logic [1:0] p, logic l);
    case (p)
      2'd1: lane_in = l ? {d[1:0], r[7:2]} : {r[5:0], d[1:0]};
      2'd2: lane_in = l ? {d, r[7:4]} : {r[3:0], d};
      default: lane_in = l ? {d[1], r[7:1]} : {r[6:0], d[1]};
    endcase
  endfunction

  wire tx_full  = tx_cnt == FULL_N;
  wire rx_full  = rx_cnt == FULL_N;
  wire rx_empty = rx_cnt == '0;
  wire wr_txd   = reg_wr && reg_addr == 3'd3;
  wire rd_rxd   = reg_rd && reg_addr == 3'd4;
  wire tx_push  = wr_txd && !tx_full;
  wire rx_pop   = rd_rxd && !rx_empty;
  wire start    = frame_req && frame_go;
  wire cpha     = mode_q[0];
  wire [7:0] tx_head = txm[tx_rp];
  wire [7:0] rx_head = rxm[rx_rp];

  wire [3:0] flen = (len_q == 4'd0 || len_q > 4'd8) ? 4'd8 : len_q;
  wire [7:0] lmask = 8'hFF >> (4'd8 - flen);
  logic [3:0] nsteps, tbits;
  always_comb begin
    case (proto_q)
      2'd1: begin nsteps = (flen + 4'd1) >> 1; tbits = {nsteps[2:0], 1'b0}; end
      2'd2: begin nsteps = (flen + 4'd3) >> 2; tbits = {nsteps[1:0], 2'b00}; end
      default: begin nsteps = flen; tbits = flen; end
    endcase
  end

  wire hit    = busy && cnt == div_q;
  wire lead   = hit && !half;
  wire trail  = hit && half;
  wire last   = step == nsteps - 4'd1;
  wire fin    = trail && last;
  wire launch = cpha ? lead : (trail && !last);
  wire sample = cpha ? trail : lead;
  wire [7:0] ld = lsb_q ? (tx_head & lmask) : (tx_head << (4'd8 - flen));
  wire [7:0] rx_ins = lane_in(rx, dq_i, proto_q, lsb_q);
  wire [7:0] rfin = cpha ? rx_ins : rx;
  wire [7:0] rx_word = (lsb_q ? rfin >> (4'd8 - tbits) : rfin >> (tbits - flen)) & lmask;
  wire rx_push = fin && !txo_q && !rx_full;

  assign frame_req = !busy && tx_cnt != '0;
  assign sck = mode_q[1] ^ (busy & half);
  assign dq_o = outq & dq_oe;

  always_comb begin
    dq_oe = 4'b0;
    if (busy)
      case (proto_q)
        2'd1: dq_oe = txo_q ? 4'b0011 : 4'b0000;
        2'd2: dq_oe = txo_q ? 4'b1111 : 4'b0000;
        default: dq_oe = 4'b0001;
      endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {{(32-DIVW){1'b0}}, div_q};
      3'd1: reg_rdata = {30'b0, mode_q};
      3'd2: reg_rdata = {12'b0, len_q, 12'b0, txo_q, lsb_q, proto_q};
      3'd3: reg_rdata = {tx_full, 31'b0};
      3'd4: reg_rdata = {rx_empty, 23'b0, rx_empty ? 8'h00 : rx_head};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIVW'(1); mode_q <= '0; proto_q <= '0;
      lsb_q <= 1'b0; txo_q <= 1'b0; len_q <= 4'd8;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: div_q <= reg_wdata[DIVW-1:0];
        3'd1: mode_q <= reg_wdata[1:0];
        3'd2: begin
          proto_q <= reg_wdata[1:0]; lsb_q <= reg_wdata[2];
          txo_q <= reg_wdata[3]; len_q <= reg_wdata[19:16];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rxm[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0; tx_rp <= '0; tx_wp <= '0;
      rx_cnt <= '0; rx_rp <= '0; rx_wp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (start)   tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(start);
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; half <= 1'b0; cnt <= '0; step <= '0;
      sh <= '0; rx <= '0; outq <= '0; frame_done <= 1'b0;
    end else begin
      frame_done <= fin;
      if (start) begin
        busy <= 1'b1; half <= 1'b0; cnt <= '0; step <= '0;
        sh <= cpha ? ld : lane_shift(ld, proto_q, lsb_q);
        if (!cpha) outq <= lane_out(ld, proto_q, lsb_q);
      end else if (busy) begin
        cnt <= hit ? '0 : cnt + DIVW'(1);
        if (hit) half <= ~half;
        if (trail) step <= step + 4'd1;
        if (fin) busy <= 1'b0;
        if (launch) begin
          outq <= lane_out(sh, proto_q, lsb_q);
          sh <= lane_shift(sh, proto_q, lsb_q);
        end
        if (sample) rx <= rx_ins;
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int CW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic frame_req,
  input logic frame_go,
  input logic frame_done,
  input logic sck,
  input logic cpol,
  input logic [3:0] dq_oe,
  input logic busy,
  input logic hit,
  input logic fin,
  input logic txo,
  input logic rx_pop,
  input logic [CW-1:0] rx_cnt,
  input logic tx_full,
  input logic wr_txd,
  input logic tx_pop
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R10
  start_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && frame_go) |=> !frame_req);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (sck == cpol));
  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (dq_oe == 4'b0000));
  // R2
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit) |=> $stable(sck));
  // R7
  txonly_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && txo && !rx_pop) |=> $stable(rx_cnt));
  // R8
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_txd && !tx_pop) |=> tx_full);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_go(frame_go),
  .frame_done(frame_done), .sck(sck), .cpol(mode_q[1]), .dq_oe(dq_oe),
  .busy(busy), .hit(hit), .fin(fin), .txo(txo_q), .rx_pop(rx_pop),
  .rx_cnt(rx_cnt), .tx_full(tx_full), .wr_txd(wr_txd), .tx_pop(start)
);

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
  localparam int DEPTH = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, frame_go = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] dq_i = '0;
  logic [31:0] reg_rdata;
  logic frame_req, frame_done, sck;
  logic [3:0] dq_o, dq_oe;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_req(frame_req), .frame_go(frame_go), .frame_done(frame_done),
    .sck(sck), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int ncmp = 0, nbad = 0, cyc = 0, seed = 7;
  bit finished = 0;

  int m_div = 1, m_mode = 0, m_proto = 0, m_lsb = 0, m_txo = 0, m_len = 8;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit rxbits[$];
  bit mbusy = 0, mdone = 0;
  int mm = 0;
  logic [7:0] cur = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nl();
    return (m_proto == 1) ? 2 : (m_proto == 2) ? 4 : 1;
  endfunction
  function automatic int el();
    return (m_len == 0 || m_len > 8) ? 8 : m_len;
  endfunction
  function automatic int nst();
    return (el() + nl() - 1) / nl();
  endfunction

  function automatic logic [3:0] exp_chunk(int j);
    logic [3:0] v = '0;
    for (int i = 0; i < nl(); i++) begin
      int k = j * nl() + i;
      bit b = 0;
      if (k < el()) b = (m_lsb != 0) ? cur[k] : cur[el()-1-k];
      v[(m_lsb != 0) ? i : nl()-1-i] = b;
    end
    return v;
  endfunction

  function automatic logic [3:0] exp_oe();
    if (!mbusy) return 4'b0000;
    if (m_proto == 1) return (m_txo != 0) ? 4'b0011 : 4'b0000;
    if (m_proto == 2) return (m_txo != 0) ? 4'b1111 : 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic [31:0] exp_rdata(int a);
    case (a)
      0: return 32'(m_div);
      1: return 32'(m_mode);
      2: return 32'((m_len << 16) | (m_txo << 3) | (m_lsb << 2) | m_proto);
      3: return (txq.size() >= DEPTH) ? 32'h8000_0000 : 32'h0;
      4: return (rxq.size() == 0) ? 32'h8000_0000 : {24'h0, rxq[0]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic take_sample();
    for (int i = 0; i < nl(); i++) begin
      int lane = (m_lsb != 0) ? i : nl()-1-i;
      if (nl() == 1) lane = 1;
      rxbits.push_back(dq_i[lane]);
    end
  endtask

  task automatic model_step();
    int pre_tx = txq.size();
    int pre_rx = rxq.size();
    int P = 2 * (m_div + 1);
    int H = m_div + 1;
    bit dn = 0;
    if (mbusy) begin
      int m1 = mm + 1;
      if ((m1 % P) == H && m_mode[0] == 0) take_sample();
      if ((m1 % P) == 0 && m_mode[0] == 1) take_sample();
      if (m1 == nst() * P) begin
        logic [7:0] v = '0;
        mbusy = 0; dn = 1;
        for (int k = 0; k < el(); k++)
          v[(m_lsb != 0) ? k : el()-1-k] = rxbits[k];
        if (m_txo == 0 && pre_rx < DEPTH) rxq.push_back(v);
      end else mm = m1;
    end else if (pre_tx > 0 && frame_go) begin
      cur = txq.pop_front();
      mbusy = 1; mm = 0; rxbits.delete();
    end
    if (reg_rd && reg_addr == 3'd4 && pre_rx > 0) void'(rxq.pop_front());
    if (reg_wr) begin
      case (reg_addr)
        3'd0: m_div = int'(reg_wdata[11:0]);
        3'd1: m_mode = int'(reg_wdata[1:0]);
        3'd2: begin
          m_proto = int'(reg_wdata[1:0]); m_lsb = int'(reg_wdata[2]);
          m_txo = int'(reg_wdata[3]); m_len = int'(reg_wdata[19:16]);
        end
        3'd3: if (pre_tx < DEPTH) txq.push_back(reg_wdata[7:0]);
        default: ;
      endcase
    end
    mdone = dn;
  endtask

  task automatic compare_pins();
    int P = 2 * (m_div + 1);
    int H = m_div + 1;
    bit hi = mbusy && ((mm % P) >= H);
    chk("R2/R3 sck", 32'(sck), 32'(m_mode[1] ^ hi));
    chk("R10 frame_req", 32'(frame_req), 32'(!mbusy && txq.size() > 0));
    chk("R10 frame_done", 32'(frame_done), 32'(mdone));
    chk("R4/R7 dq_oe", 32'(dq_oe), 32'(exp_oe()));
    if (mbusy && (m_mode[0] == 0 || (mm % P) >= H))
      chk("R4/R5/R6 dq_o", 32'(dq_o), 32'(exp_chunk(mm / P) & exp_oe()));
  endtask

  string rd_tag = "R1 readback";

  task automatic cycle();
    seed = seed * 1103515245 + 12345;
    dq_i = seed[19:16];
    #1;
    if (reg_rd) chk(rd_tag, reg_rdata, exp_rdata(int'(reg_addr)));
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_pins();
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    cycle();
    reg_wr = 0;
  endtask

  task automatic rd(int a, string tag);
    reg_rd = 1; reg_addr = 3'(a); rd_tag = tag;
    cycle();
    reg_rd = 0;
  endtask

  task automatic run_frames();
    frame_go = 1;
    for (int i = 0; i < 20000; i++) begin
      cycle();
      if (!mbusy && txq.size() == 0 && !mdone) break;
    end
    frame_go = 0;
  endtask

  function automatic logic [31:0] fmtv(int p, int l, int t, int n);
    return 32'((n << 16) | (t << 3) | (l << 2) | p);
  endfunction

  task automatic drain(string tag);
    for (int i = 0; i < DEPTH + 1; i++) rd(4, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      ncmp++; nbad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_pins();
    // R1 reset state of the registers
    chk("R1 sck idle", 32'(sck), 32'h0);
    rd(0, "R1 divisor"); rd(1, "R1 mode"); rd(2, "R1 format");
    rd(3, "R1 txdata"); rd(4, "R1 rxdata");

    // R10 request held without grant, no SCK activity
    wr(3, 32'h5A);
    repeat (6) cycle();
    chk("R10 request waits", 32'(frame_req), 32'h1);
    run_frames();
    rd(4, "R9 rxdata single");

    // R4 R5 single mode MSB first, mode 0
    wr(3, 32'hA5); wr(3, 32'h3C);
    run_frames();
    rd(4, "R9 rxdata"); rd(4, "R9 rxdata"); rd(4, "R9 empty");

    // R3 R5 R6 mode 3, LSB first, length 5
    wr(1, 32'h3); wr(0, 32'h2); wr(2, fmtv(0, 1, 0, 5));
    rd(2, "R6 format readback");
    wr(3, 32'hD7); wr(3, 32'h19);
    run_frames();
    drain("R5/R6 rxdata lsb len5");

    // R4 R7 dual transmit-only, mode 1, divisor 0
    wr(1, 32'h1); wr(0, 32'h0); wr(2, fmtv(1, 0, 1, 8));
    wr(3, 32'hC6); wr(3, 32'h81);
    run_frames();
    rd(4, "R7 no receive push");

    // R4 dual receive, length 7
    wr(2, fmtv(1, 1, 0, 7));
    wr(3, 32'h55);
    run_frames();
    rd(4, "R4/R6 dual rxdata");

    // R4 quad receive LSB, mode 2; quad MSB length 5 transmit-only
    wr(1, 32'h2); wr(0, 32'h1); wr(2, fmtv(2, 1, 0, 8));
    wr(3, 32'h9E);
    run_frames();
    rd(4, "R4 quad rxdata");
    wr(2, fmtv(2, 0, 1, 5));
    wr(3, 32'h17);
    run_frames();
    rd(4, "R7 quad no push");
    wr(2, fmtv(2, 0, 0, 5));
    wr(3, 32'h0B);
    run_frames();
    rd(4, "R6 quad len5 rxdata");

    // R4 protocol 3 acts as single; R6 lengths 0 and 12 act as 8
    wr(1, 32'h0); wr(2, fmtv(3, 0, 0, 0));
    wr(3, 32'hE1);
    run_frames();
    rd(4, "R4/R6 proto3 len0");
    wr(2, fmtv(0, 1, 0, 12));
    wr(3, 32'h6D);
    run_frames();
    rd(4, "R6 len12");

    // R7 single transmit-only still drives DQ0, keeps nothing
    wr(2, fmtv(0, 0, 1, 8));
    wr(3, 32'hF0);
    run_frames();
    rd(4, "R7 single no push");

    // R8 full transmit queue drops the extra write; R9 full receive queue discards
    wr(2, fmtv(0, 0, 0, 8));
    for (int i = 0; i < DEPTH + 1; i++) wr(3, 32'(8'h20 + i));
    rd(3, "R8 txdata full");
    run_frames();
    rd(3, "R8 txdata not full");
    wr(3, 32'h77);
    run_frames();
    drain("R9 rx full discard");
    rd(4, "R9 empty after drain");

    repeat (4) cycle();
    summary();
  end
endmodule